// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the register front end of a general-purpose I/O port with up to 32 pins. A bus master reaches it through a simple valid/ready word bus with a 12-bit byte offset. Through that bus it sets the level each pin drives, sets the pin's direction, and writes a 32-bit configuration word for each pin. It also reads back the resolved pin levels, which come from the pad logic on `pin_in`. The stored output levels, the directions and the per-pin configuration words leave the block as plain vectors for the pad resolver.

Output levels and directions can each be changed in three ways: by overwriting the whole register, by setting bits (write-one-to-set) or by clearing bits (write-one-to-clear). The direction of a pin is held in two places: the port-wide direction register and bit 0 of that pin's configuration word. Every write keeps the two copies equal. A direction write updates bit 0 of all configuration words, and a configuration write updates the matching direction bit. Any access to an offset that maps to no register, and any write to the read-only input register, is answered with an error flag. Such an access changes no state.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, reads of the output (0x504), input (0x510) and direction (0x514) registers return 0. Every configuration word (0x700 + 4*i) reads 0x00000002. `pad_out` and `pad_dir` are 0.
- R2: A write to 0x504 replaces the output register with the written data. `pad_out` shows the new value from the clock edge that accepts the write.
- R3: A write to 0x508 ORs the data into the output register. A write to 0x50C clears every output bit that is 1 in the data. All other bits keep their value.
- R4: A read of 0x504, 0x508 or 0x50C returns the current output register.
- R5: Offsets 0x514 (replace), 0x518 (set) and 0x51C (clear) apply the same three write rules to the direction register. A read of any of the three returns it. `pad_dir` follows the register.
- R6: After any direction write, bit 0 of configuration word i equals direction bit i, for every pin. Bits 31..1 of each configuration word are left unchanged.
- R7: A write to configuration word i (offset 0x700 + 4*i, i < NUM_PINS) stores the full word. It also copies data bit 0 into direction bit i and leaves the other direction bits unchanged.
- R8: A read of 0x510 returns `pin_in` as sampled at the clock edge before the edge that accepts the read. A write to 0x510 is ignored and flagged with `rsp_err`.
- R9: An access to an unmapped or misaligned offset returns read data 0 with `rsp_err` = 1 and changes no register. Accesses to mapped offsets give `rsp_err` = 0.
- R10: `req_ready` is always 1. Every accepted request gives exactly one `rsp_valid` pulse on the next clock edge, and `rsp_valid` stays low when no request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the request accepted on the previous edge |
| rsp_rdata | output | DATA_W | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access hit no register, or wrote the read-only input |
| pin_in | input | NUM_PINS | Resolved pin levels from the pad logic |
| pad_out | output | NUM_PINS | Stored output levels |
| pad_dir | output | NUM_PINS | Stored directions (1 = output) |
| pin_cfg | output | NUM_PINS*DATA_W | Configuration words, pin i at bits [i*DATA_W +: DATA_W] |

## Verification
State changes from a write show on `pad_out`, `pad_dir` and `pin_cfg` right after the accepting edge. The bench drives each request at a falling edge and compares these vectors at the next falling edge. A read's data and the error flag of any access are registered on the accepting edge, so they are sampled at that same following falling edge, together with a check that `rsp_valid` is high. The input register adds one sampling stage: the bench changes `pin_in` and lets one full cycle pass before it reads. In one case it changes `pin_in` in the same cycle as the read and expects the older value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned OFS_OUT     = 32'h504;
    localparam int unsigned OFS_OUTSET  = 32'h508;
    localparam int unsigned OFS_OUTCLR  = 32'h50C;
    localparam int unsigned OFS_IN      = 32'h510;
    localparam int unsigned OFS_DIR     = 32'h514;
    localparam int unsigned OFS_DIRSET  = 32'h518;
    localparam int unsigned OFS_DIRCLR  = 32'h51C;
    localparam int unsigned OFS_CFG_BASE = 32'h700;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_OUT,
        RK_OUTSET,
        RK_OUTCLR,
        RK_IN,
        RK_DIR,
        RK_DIRSET,
        RK_DIRCLR,
        RK_CFG
    } reg_kind_e;

    typedef enum logic [1:0] {
        WOP_NONE,
        WOP_REPLACE,
        WOP_SET,
        WOP_CLEAR
    } wr_op_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_PINS = 32,
    localparam int unsigned IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  pin_idx
);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-3:0] word;
    logic              in_cfg;

    always_comb begin
        rel     = addr - ADDR_W'(OFS_CFG_BASE);
        word    = rel[ADDR_W-1:2];
        in_cfg  = (addr >= ADDR_W'(OFS_CFG_BASE)) && (rel[1:0] == 2'b00)
                  && ({2'b00, word} < ADDR_W'(NUM_PINS));
        pin_idx = word[IDX_W-1:0];

        if (in_cfg) begin
            kind = RK_CFG;
        end else begin
            case (addr)
                ADDR_W'(OFS_OUT):    kind = RK_OUT;
                ADDR_W'(OFS_OUTSET): kind = RK_OUTSET;
                ADDR_W'(OFS_OUTCLR): kind = RK_OUTCLR;
                ADDR_W'(OFS_IN):     kind = RK_IN;
                ADDR_W'(OFS_DIR):    kind = RK_DIR;
                ADDR_W'(OFS_DIRSET): kind = RK_DIRSET;
                ADDR_W'(OFS_DIRCLR): kind = RK_DIRCLR;
                default:             kind = RK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_op_e       op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val_q
);

    logic [W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        case (op)
            WOP_REPLACE: val_d = wdata;
            WOP_SET:     val_d = val_q | wdata;
            WOP_CLEAR:   val_d = val_q & ~wdata;
            default:     val_d = val_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assert_replace_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op == WOP_REPLACE |=> val_q == $past(wdata));

    assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op == WOP_SET |=> (val_q & $past(wdata)) == $past(wdata));

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op == WOP_CLEAR |=> (val_q & $past(wdata)) == '0);

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op == WOP_NONE |=> $stable(val_q));

endmodule

// File: rtl/gpio_dir_cfg.sv
module gpio_dir_cfg
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned DATA_W   = 32,
    parameter logic [DATA_W-1:0] CFG_RST = 32'h0000_0002,
    localparam int unsigned IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  wr_op_e                     dir_op,
    input  logic                       cfg_we,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_PINS-1:0]        dir_o,
    output logic [NUM_PINS*DATA_W-1:0] cfg_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0]             dir;
        logic [NUM_PINS-1:0][DATA_W-1:0] cfg;
    } mirror_t;

    mirror_t st_d, st_q;
    logic [NUM_PINS-1:0] wbits;

    assign wbits = wdata[NUM_PINS-1:0];

    always_comb begin
        st_d = st_q;
        case (dir_op)
            WOP_REPLACE: st_d.dir = wbits;
            WOP_SET:     st_d.dir = st_q.dir | wbits;
            WOP_CLEAR:   st_d.dir = st_q.dir & ~wbits;
            default:     st_d.dir = st_q.dir;
        endcase
        if (dir_op != WOP_NONE) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                st_d.cfg[i][0] = st_d.dir[i];
            end
        end
        if (cfg_we) begin
            st_d.cfg[cfg_idx]  = wdata;
            st_d.dir[cfg_idx]  = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= {NUM_PINS{CFG_RST[0]}};
            for (int i = 0; i < NUM_PINS; i++) begin
                st_q.cfg[i] <= CFG_RST;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o = st_q.dir;
    assign cfg_o = st_q.cfg;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
        // Both copies agree at all times (R6 and R7)
        assert_mirror_coherent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.dir[g] == st_q.cfg[g][0]);

        assert_dirwr_keeps_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
            dir_op != WOP_NONE |=> st_q.cfg[g][DATA_W-1:1] == $past(st_q.cfg[g][DATA_W-1:1]));

        assert_cfgwr_stores_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_idx == IDX_W'(g)) |=> st_q.cfg[g] == $past(wdata));

        assert_cfgwr_spares_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_idx != IDX_W'(g) && dir_op == WOP_NONE) |=> $stable(st_q.dir[g]));
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,   // must not exceed DATA_W
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 12,
    parameter logic [DATA_W-1:0] CFG_RST = 32'h0000_0002,
    localparam int unsigned IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       rsp_err,
    input  logic [NUM_PINS-1:0]        pin_in,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_dir,
    output logic [NUM_PINS*DATA_W-1:0] pin_cfg
);

    typedef struct packed {
        logic [NUM_PINS-1:0] in_smp;
        logic                rsp_valid;
        logic                rsp_err;
        logic [DATA_W-1:0]   rsp_rdata;
    } front_t;

    front_t            st_d, st_q;
    reg_kind_e         kind;
    logic [IDX_W-1:0]  pin_idx;
    logic              do_wr;
    wr_op_e            out_op;
    wr_op_e            dir_op;
    logic              cfg_we;
    logic [DATA_W-1:0] rd_val;
    logic              bad;

    gpio_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_PINS (NUM_PINS)
    ) u_decode (
        .addr    (req_addr),
        .kind    (kind),
        .pin_idx (pin_idx)
    );

    assign req_ready = 1'b1;
    assign do_wr     = req_valid && req_write;

    always_comb begin
        out_op = WOP_NONE;
        dir_op = WOP_NONE;
        cfg_we = 1'b0;
        if (do_wr) begin
            case (kind)
                RK_OUT:    out_op = WOP_REPLACE;
                RK_OUTSET: out_op = WOP_SET;
                RK_OUTCLR: out_op = WOP_CLEAR;
                RK_DIR:    dir_op = WOP_REPLACE;
                RK_DIRSET: dir_op = WOP_SET;
                RK_DIRCLR: dir_op = WOP_CLEAR;
                RK_CFG:    cfg_we = 1'b1;
                default:   ;
            endcase
        end
    end

    gpio_setclr_reg #(
        .W (NUM_PINS)
    ) u_out_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (out_op),
        .wdata (req_wdata[NUM_PINS-1:0]),
        .val_q (pad_out)
    );

    gpio_dir_cfg #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .CFG_RST  (CFG_RST)
    ) u_dir_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_op  (dir_op),
        .cfg_we  (cfg_we),
        .cfg_idx (pin_idx),
        .wdata   (req_wdata),
        .dir_o   (pad_dir),
        .cfg_o   (pin_cfg)
    );

    always_comb begin
        case (kind)
            RK_OUT, RK_OUTSET, RK_OUTCLR: rd_val = DATA_W'(pad_out);
            RK_IN:                        rd_val = DATA_W'(st_q.in_smp);
            RK_DIR, RK_DIRSET, RK_DIRCLR: rd_val = DATA_W'(pad_dir);
            RK_CFG:                       rd_val = pin_cfg[pin_idx*DATA_W +: DATA_W];
            default:                      rd_val = '0;
        endcase
        bad = (kind == RK_NONE) || (req_write && kind == RK_IN);

        st_d           = st_q;
        st_d.in_smp    = pin_in;
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = req_valid && bad;
        st_d.rsp_rdata = (req_valid && !req_write && !bad) ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rsp_rdata;

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_err_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> rsp_rdata == '0);

    assert_bad_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && kind == RK_NONE) |=> ($stable(pad_out) && $stable(pad_dir) && $stable(pin_cfg)));

    assert_in_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && kind == RK_IN) |=> ($stable(pad_out) && $stable(pad_dir) && $stable(pin_cfg) && rsp_err));

endmodule

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_dir;
    logic [NP*32-1:0] pin_cfg;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [31:0] m_out, m_dir, m_in;
    logic [31:0] m_cfg [NP];

    always #2 clk = ~clk;

    gpio_port_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .pin_in(pin_in), .pad_out(pad_out), .pad_dir(pad_dir), .pin_cfg(pin_cfg)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit is_cfg(input logic [11:0] a);
        return a >= 12'h700 && a < 12'h780 && a[1:0] == 2'b00;
    endfunction

    function automatic bit mapped(input logic [11:0] a, input bit wr);
        if (is_cfg(a)) return 1'b1;
        case (a)
            12'h504, 12'h508, 12'h50C, 12'h514, 12'h518, 12'h51C: return 1'b1;
            12'h510: return !wr;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (is_cfg(a)) return m_cfg[(a - 12'h700) >> 2];
        case (a)
            12'h504, 12'h508, 12'h50C: return m_out;
            12'h514, 12'h518, 12'h51C: return m_dir;
            12'h510: return m_in;
            default: return 32'h0;
        endcase
    endfunction

    // Called at a falling edge; returns at the falling edge after the response.
    task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R10", "rsp_valid after request", {31'b0, rsp_valid}, 32'h1);
        check("R10", "req_ready", {31'b0, req_ready}, 32'h1);
        rd = rsp_rdata; er = rsp_err;
    endtask

    task automatic check_pads(input string req);
        check(req, "pad_out", pad_out, m_out);
        check(req, "pad_dir", pad_dir, m_dir);
        for (int i = 0; i < NP; i++) begin
            check(req, $sformatf("pin_cfg[%0d]", i), pin_cfg[i*32 +: 32], m_cfg[i]);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
        logic [31:0] rd; logic er;
        access(1'b1, a, d, rd, er);
        if (is_cfg(a)) begin
            m_cfg[(a - 12'h700) >> 2] = d;
            m_dir[(a - 12'h700) >> 2] = d[0];
        end else begin
            case (a)
                12'h504: m_out = d;
                12'h508: m_out = m_out | d;
                12'h50C: m_out = m_out & ~d;
                12'h514: m_dir = d;
                12'h518: m_dir = m_dir | d;
                12'h51C: m_dir = m_dir & ~d;
                default: ;
            endcase
            if (a == 12'h514 || a == 12'h518 || a == 12'h51C)
                for (int i = 0; i < NP; i++) m_cfg[i][0] = m_dir[i];
        end
        check(mapped(a, 1'b1) ? req : "R9", $sformatf("write err @%h", a), {31'b0, er}, {31'b0, !mapped(a, 1'b1)});
        check_pads(req);
    endtask

    task automatic rdchk(input logic [11:0] a, input string req);
        logic [31:0] rd; logic er;
        access(1'b0, a, 32'h0, rd, er);
        check(req, $sformatf("read data @%h", a), rd, exp_read(a));
        check(mapped(a, 1'b0) ? req : "R9", $sformatf("read err @%h", a), {31'b0, er}, {31'b0, !mapped(a, 1'b0)});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #400000;
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL R10 watchdog expired: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] bad_ofs [8];
        logic [31:0] pat;
        m_out = '0; m_dir = '0; m_in = '0;
        for (int i = 0; i < NP; i++) m_cfg[i] = 32'h2;
        bad_ofs = '{12'h000, 12'h500, 12'h505, 12'h520, 12'h6FC, 12'h702, 12'h780, 12'hFFC};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_pads("R1");
        check("R10", "rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
        rdchk(12'h504, "R1");
        rdchk(12'h510, "R1");
        rdchk(12'h514, "R1");
        for (int i = 0; i < NP; i++) rdchk(12'h700 + 12'(4*i), "R1");

        // R2 / R3 / R4: output register views
        for (int k = 0; k < 8; k++) begin
            pat = 32'h9E37_79B9 * (k + 1);
            wr(12'h504, pat, "R2");
            rdchk(12'h504, "R4"); rdchk(12'h508, "R4"); rdchk(12'h50C, "R4");
            wr(12'h508, pat ^ 32'h0F0F_00FF, "R3");
            rdchk(12'h508, "R4");
            wr(12'h50C, 32'h3 << (k * 4), "R3");
            rdchk(12'h50C, "R4");
        end
        wr(12'h504, 32'hFFFF_FFFF, "R2");
        wr(12'h50C, 32'hFFFF_FFFF, "R3");
        wr(12'h508, 32'h0, "R3");
        rdchk(12'h504, "R4");

        // R7: per-pin configuration sweep, every pin
        for (int i = 0; i < NP; i++) begin
            pat = (32'h85EB_CA6B * (i + 3)) ^ 32'(i);
            wr(12'h700 + 12'(4*i), pat, "R7");
        end
        for (int i = 0; i < NP; i++) rdchk(12'h700 + 12'(4*i), "R7");
        rdchk(12'h514, "R7");

        // R5 / R6: direction views and mirroring into configuration bit 0
        for (int k = 0; k < 6; k++) begin
            pat = 32'hC2B2_AE35 * (k + 5);
            wr(12'h514, pat, "R6");
            rdchk(12'h514, "R5"); rdchk(12'h518, "R5"); rdchk(12'h51C, "R5");
            wr(12'h518, 32'h1 << (k * 5), "R6");
            wr(12'h51C, 32'hF << (k * 4), "R6");
            rdchk(12'h51C, "R5");
            rdchk(12'h700 + 12'(4*k), "R6");
        end
        wr(12'h514, 32'h0, "R5");
        wr(12'h518, 32'hFFFF_FFFF, "R5");
        wr(12'h77C, 32'hABCD_0000, "R7");
        rdchk(12'h514, "R7");
        wr(12'h700, 32'h0000_0003, "R7");
        rdchk(12'h514, "R7");

        // R8: input sampling and read-only behaviour
        for (int k = 0; k < 6; k++) begin
            pat = 32'h27D4_EB2F * (k + 1);
            pin_in = pat;
            @(negedge clk);
            m_in = pat;
            rdchk(12'h510, "R8");
        end
        pin_in = 32'h1234_5678;
        @(negedge clk);
        m_in = 32'h1234_5678;
        pin_in = 32'hDEAD_BEEF;
        rdchk(12'h510, "R8");
        wr(12'h510, 32'hFFFF_FFFF, "R8");

        // R9: unmapped and misaligned offsets, read and write
        for (int k = 0; k < 8; k++) begin
            rdchk(bad_ofs[k], "R9");
            wr(bad_ofs[k], 32'h5A5A_A5A5 ^ 32'(k), "R9");
        end

        // R10: no response without a request
        @(negedge clk);
        check("R10", "rsp_valid idle", {31'b0, rsp_valid}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule